// File: doc/BRIEF.md
# Flash Write-Cycle Address Binder

This block sits on the bus side of a NOR-style flash model. It watches chip enable, write enable, address-valid, the bus clock, the address bus and the data bus, and decides which address goes with the data of each write cycle. All bus pins are oversampled on a fast system clock. Every pin passes through a two-flop synchronizer, and every edge is found by comparing successive samples.

A configuration input selects the bus mode. In asynchronous mode the address on the bus in the sample where write enable rises is used. In synchronous mode the address can come from one of four sources:
- the first bus-clock rise while address-valid is low;
- a rise of address-valid;
- a bus address that has stayed stable long enough while the clock is stopped and address-valid is low;
- the address remembered from the previous write.

When write enable rises, the block emits a one-cycle strobe. The strobe carries the address, the data and a 2-bit source code. The block also flags writes that have no trustworthy address, and bus-clock or address-valid rises that arrive too soon after a write.

Top module: `flash_wr_capture`

## Requirements
- R1: `cfgAsync`=0 selects synchronous mode and `cfgAsync`=1 selects asynchronous mode. In asynchronous mode every write takes its address from the bus in the sample where write enable rises, with source code 2. Bus-clock and address-valid edges neither latch an address nor raise `turnViol`.
- R2: In synchronous mode, with chip enable low, the first bus-clock rise seen while address-valid is low latches the bus address. Later clock rises in the same cycle do not replace it. The write reports that address with source code 0.
- R3: In synchronous mode, a rise of address-valid with chip enable low latches the bus address. The write reports that address with source code 1.
- R4: In synchronous mode, a write with no latched address and address-valid low uses the current bus address, with source code 2. This happens only if the address has been unchanged for at least STABLE_MIN samples before write enable rises. That address becomes the remembered address.
- R5: In synchronous mode, a write with no latched address and address-valid high reuses the remembered address, with source code 3. This still holds when cycles are separated only by toggling write enable or chip enable.
- R6: A source-code-3 write raises `addrErr` with the strobe in two cases: no address has been remembered since reset, or address-valid is low but the stability window was not met. In the second case the remembered address is still reported.
- R7: `wrStrobe` is high for exactly one system cycle per write-enable rise taken with chip enable low. `wrData` is the data bus value in that sample.
- R8: In synchronous mode, a bus-clock rise or address-valid rise with chip enable low, within GAP_MIN samples after write enable rises, raises a one-cycle `turnViol`.
- R9: After reset all outputs are 0, the remembered address is 0 and no address counts as remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Active-low reset |
| cfgAsync | input | 1 | 1 = asynchronous bus, 0 = synchronous bus |
| busClk | input | 1 | Bus clock pin |
| busCeN | input | 1 | Chip enable, active low |
| busWeN | input | 1 | Write enable, active low |
| busAdvN | input | 1 | Address valid, active low |
| busAddr | input | ADDR_W | Address bus |
| busData | input | DATA_W | Data bus |
| wrStrobe | output | 1 | One-cycle write strobe |
| wrAddr | output | ADDR_W | Address bound to the write |
| wrData | output | DATA_W | Data of the write |
| wrSrc | output | 2 | Source: 0 clock, 1 address-valid rise, 2 bus, 3 remembered |
| addrErr | output | 1 | Write had no trustworthy address |
| turnViol | output | 1 | Clock or address-valid rise too soon after a write |

## Verification
The bench builds the block with 16-bit address and data buses, STABLE_MIN of 4 samples and GAP_MIN of 6 samples. With these values the bench can place an address change one sample before write enable rises, which falls short of the stability window. It can also place clock and address-valid rises two or three samples after a write, inside the turnaround window, and twenty samples after, well outside it. A handful of bench cycles therefore covers both the passing and the failing side of each timing rule.

// File: rtl/wrcap_pkg.sv
`timescale 1ns/1ps
package wrcap_pkg;

  typedef enum logic [1:0] {
    SRC_CLK   = 2'd0,
    SRC_ADV   = 2'd1,
    SRC_BUS   = 2'd2,
    SRC_REUSE = 2'd3
  } srcCode_t;

  typedef struct packed {
    logic     latch;    // capture bus address into the held register
    logic     emit;     // issue a write strobe this cycle
    logic     fromBus;  // strobe uses the live bus address
    srcCode_t src;      // source code reported with the strobe
    logic     flagErr;  // strobe carries an address error
  } ctlStrobes_t;

endpackage

// File: rtl/wrcap_sync.sv
`timescale 1ns/1ps
module wrcap_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);

  logic [STAGES-1:0][W-1:0] stg;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stg[0] <= RST_VAL;
          else       stg[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stg[i] <= RST_VAL;
          else       stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prev <= RST_VAL;
    else       prev <= stg[STAGES-1];
  end

  assign cur = stg[STAGES-1];

endmodule

// File: rtl/wrcap_ctrl.sv
`timescale 1ns/1ps
module wrcap_ctrl
  import wrcap_pkg::*;
#(
  parameter int GAP_MIN = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgAsync,
  input  logic        sCeN,
  input  logic        sWeN,
  input  logic        sAdvN,
  input  logic        sClk,
  input  logic        pWeN,
  input  logic        pAdvN,
  input  logic        pClk,
  input  logic        stableOk,
  input  logic        addrValid,
  output ctlStrobes_t ctl,
  output logic        turnViol
);

  localparam int GW = $clog2(GAP_MIN + 1);

  logic     syncMode;
  logic     ceAct;
  logic     weRise;
  logic     clkRise;
  logic     advRise;
  logic     captured;
  srcCode_t capSrc;
  logic [GW-1:0] gapCnt;
  logic     violNow;

  assign syncMode = !cfgAsync;
  assign ceAct    = !sCeN;
  assign weRise   = sWeN && !pWeN && ceAct;
  assign clkRise  = sClk && !pClk;
  assign advRise  = sAdvN && !pAdvN;

  always_comb begin
    ctl         = '0;
    ctl.src     = SRC_REUSE;
    ctl.latch   = syncMode && ceAct && !weRise &&
                  ((clkRise && !sAdvN && !captured) || advRise);
    if (weRise) begin
      ctl.emit = 1'b1;
      if (!syncMode) begin
        ctl.fromBus = 1'b1;
        ctl.src     = SRC_BUS;
      end else if (captured) begin
        ctl.src = capSrc;
      end else if (!sAdvN && stableOk) begin
        ctl.fromBus = 1'b1;
        ctl.src     = SRC_BUS;
      end else begin
        ctl.src     = SRC_REUSE;
        ctl.flagErr = !addrValid || !sAdvN;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      captured <= 1'b0;
      capSrc   <= SRC_CLK;
    end else if (weRise) begin
      captured <= 1'b0;
    end else if (ctl.latch) begin
      captured <= 1'b1;
      capSrc   <= advRise ? SRC_ADV : SRC_CLK;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            gapCnt <= '0;
    else if (weRise)      gapCnt <= GW'(GAP_MIN);
    else if (gapCnt != 0) gapCnt <= gapCnt - 1'b1;
  end

  assign violNow = syncMode && ceAct && (gapCnt != 0) && (clkRise || advRise);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) turnViol <= 1'b0;
    else       turnViol <= violNow;
  end

endmodule

// File: rtl/wrcap_dp.sv
`timescale 1ns/1ps
module wrcap_dp
  import wrcap_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int STABLE_MIN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [ADDR_W-1:0] sAddr,
  input  logic [ADDR_W-1:0] pAddr,
  input  logic [DATA_W-1:0] sData,
  output logic              stableOk,
  output logic              addrValid,
  output logic              wrStrobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic [1:0]        wrSrc,
  output logic              addrErr
);

  localparam int SW = $clog2(STABLE_MIN + 1);

  logic [SW-1:0]     stableCnt;
  logic [ADDR_W-1:0] heldAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         stableCnt <= '0;
    else if (sAddr != pAddr)           stableCnt <= '0;
    else if (stableCnt != SW'(STABLE_MIN)) stableCnt <= stableCnt + 1'b1;
  end

  assign stableOk = (stableCnt >= SW'(STABLE_MIN));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldAddr  <= '0;
      addrValid <= 1'b0;
    end else if (ctl.latch || (ctl.emit && ctl.fromBus)) begin
      heldAddr  <= sAddr;
      addrValid <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrStrobe <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
      wrSrc    <= 2'd0;
      addrErr  <= 1'b0;
    end else begin
      wrStrobe <= ctl.emit;
      addrErr  <= ctl.emit && ctl.flagErr;
      if (ctl.emit) begin
        wrAddr <= ctl.fromBus ? sAddr : heldAddr;
        wrData <= sData;
        wrSrc  <= ctl.src;
      end
    end
  end

endmodule

// File: rtl/flash_wr_capture.sv
`timescale 1ns/1ps
module flash_wr_capture
  import wrcap_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int STABLE_MIN = 4,
  parameter int GAP_MIN    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgAsync,
  input  logic              busClk,
  input  logic              busCeN,
  input  logic              busWeN,
  input  logic              busAdvN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  output logic              wrStrobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic [1:0]        wrSrc,
  output logic              addrErr,
  output logic              turnViol
);

  localparam int BW = ADDR_W + DATA_W;

  // control pins: {ce, we, adv, clk}; strobes idle high, clock idle low
  logic [3:0]    ctlCur, ctlPrev;
  logic [BW-1:0] busCur, busPrev;
  logic          stableOk, addrValid;
  ctlStrobes_t   ctl;

  wrcap_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1110)) u_syncCtl (
    .clk(clk), .rstN(rstN),
    .din({busCeN, busWeN, busAdvN, busClk}),
    .cur(ctlCur), .prev(ctlPrev)
  );

  wrcap_sync #(.W(BW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_syncBus (
    .clk(clk), .rstN(rstN),
    .din({busAddr, busData}),
    .cur(busCur), .prev(busPrev)
  );

  wrcap_ctrl #(.GAP_MIN(GAP_MIN)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgAsync(cfgAsync),
    .sCeN(ctlCur[3]), .sWeN(ctlCur[2]), .sAdvN(ctlCur[1]), .sClk(ctlCur[0]),
    .pWeN(ctlPrev[2]), .pAdvN(ctlPrev[1]), .pClk(ctlPrev[0]),
    .stableOk(stableOk), .addrValid(addrValid),
    .ctl(ctl), .turnViol(turnViol)
  );

  wrcap_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STABLE_MIN(STABLE_MIN)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .sAddr(busCur[BW-1:DATA_W]), .pAddr(busPrev[BW-1:DATA_W]),
    .sData(busCur[DATA_W-1:0]),
    .stableOk(stableOk), .addrValid(addrValid),
    .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData),
    .wrSrc(wrSrc), .addrErr(addrErr)
  );

endmodule

// File: rtl/wrcap_checker.sv
`timescale 1ns/1ps
module wrcap_checker (
  input logic       clk,
  input logic       rstN,
  input logic       cfgAsync,
  input logic       wrStrobe,
  input logic [1:0] wrSrc,
  input logic       addrErr,
  input logic       turnViol
);

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe); // R7

  AST_ERR_ONLY_REUSE: assert property (@(posedge clk) disable iff (!rstN)
    addrErr |-> (wrStrobe && wrSrc == 2'd3)); // R6

  AST_LATCHED_NO_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && wrSrc[1] == 1'b0) |-> !addrErr); // R2

  AST_ASYNC_FROM_BUS: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && cfgAsync && $past(cfgAsync)) |-> wrSrc == 2'd2); // R1

  AST_VIOL_SYNC_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    turnViol |-> !$past(cfgAsync)); // R8

endmodule

bind flash_wr_capture wrcap_checker u_wrcapChk (
  .clk(clk), .rstN(rstN), .cfgAsync(cfgAsync),
  .wrStrobe(wrStrobe), .wrSrc(wrSrc), .addrErr(addrErr), .turnViol(turnViol)
);

// File: tb/flash_wr_capture_bench.sv
`timescale 1ns/1ps
module flash_wr_capture_bench;

  localparam int AW = 16;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgAsync = 1'b0;
  logic busClk = 1'b0, busCeN = 1'b1, busWeN = 1'b1, busAdvN = 1'b1;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busData = '0;
  logic wrStrobe, addrErr, turnViol;
  logic [AW-1:0] wrAddr;
  logic [DW-1:0] wrData;
  logic [1:0] wrSrc;

  int total = 0;
  int bad = 0;
  int violSeen = 0;

  typedef struct {
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [1:0]    src;
    logic          err;
    string         req;
  } expItem_t;

  expItem_t expQ[$];

  always #10 clk = ~clk;

  flash_wr_capture #(.ADDR_W(AW), .DATA_W(DW), .STABLE_MIN(4), .GAP_MIN(6)) u_flash_wr_capture (
    .clk(clk), .rstN(rstN), .cfgAsync(cfgAsync),
    .busClk(busClk), .busCeN(busCeN), .busWeN(busWeN), .busAdvN(busAdvN),
    .busAddr(busAddr), .busData(busData),
    .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData), .wrSrc(wrSrc),
    .addrErr(addrErr), .turnViol(turnViol)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic ok, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic [1:0] s, input logic e, input string req);
    expItem_t it;
    it.addr = a; it.data = d; it.src = s; it.err = e; it.req = req;
    expQ.push_back(it);
  endtask

  // pulse write enable with data; chip enable must already be low
  task automatic we_pulse(input logic [DW-1:0] d);
    busWeN = 1'b0; busData = d;
    step(3);
    busWeN = 1'b1;
    step(3);
  endtask

  task automatic clk_pulse();
    busClk = 1'b1; step(3);
    busClk = 1'b0; step(3);
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (rstN) begin
      if (turnViol) violSeen++;
      if (wrStrobe) begin
        if (expQ.size() == 0) begin
          check("R7", 1'b0, "unexpected strobe addr", longint'(wrAddr), 0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(it.req, wrAddr == it.addr, "addr", longint'(wrAddr), longint'(it.addr));
          check(it.req, wrData == it.data, "data (R7)", longint'(wrData), longint'(it.data));
          check(it.req, wrSrc == it.src, "src", longint'(wrSrc), longint'(it.src));
          check(it.req, addrErr == it.err, "addrErr", longint'(addrErr), longint'(it.err));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog run did not complete actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(5);
    // R9: reset state
    check("R9", wrStrobe == 1'b0, "wrStrobe", longint'(wrStrobe), 0);
    check("R9", wrAddr == '0, "wrAddr", longint'(wrAddr), 0);
    check("R9", wrSrc == 2'd0 && addrErr == 1'b0, "src/err", longint'({wrSrc, addrErr}), 0);
    check("R9", turnViol == 1'b0, "turnViol", longint'(turnViol), 0);
    rstN = 1'b1;
    step(5);

    // R6 + R9: reuse with nothing remembered -> address 0, error
    busCeN = 1'b0; step(3);
    expect_wr(16'h0000, 16'h1111, 2'd3, 1'b1, "R6");
    we_pulse(16'h1111);
    busCeN = 1'b1; step(12);

    // R2: first clock edge with ADV low latches, later edges do not
    busAdvN = 1'b0; busAddr = 16'hA1A1; step(3);
    busCeN = 1'b0; step(3);
    clk_pulse();
    busAddr = 16'h5555; clk_pulse();
    busAddr = 16'hFFFF; step(3);
    expect_wr(16'hA1A1, 16'h2222, 2'd0, 1'b0, "R2");
    we_pulse(16'h2222);
    busCeN = 1'b1; step(12);

    // R3: ADV rising edge latches
    busAddr = 16'hB2B2; busCeN = 1'b0; step(3);
    busAdvN = 1'b1; step(3);
    busAddr = 16'h7777; step(3);
    expect_wr(16'hB2B2, 16'h3333, 2'd1, 1'b0, "R3");
    we_pulse(16'h3333);
    busCeN = 1'b1; step(12);

    // R5: reuse, separated by CE toggle and by WE toggle only
    busCeN = 1'b0; step(3);
    expect_wr(16'hB2B2, 16'h4444, 2'd3, 1'b0, "R5");
    we_pulse(16'h4444);
    step(10);
    expect_wr(16'hB2B2, 16'h4545, 2'd3, 1'b0, "R5");
    we_pulse(16'h4545);
    busCeN = 1'b1; step(12);

    // R4: stable bus with clock stopped and ADV low
    busAdvN = 1'b0; step(3);
    busAddr = 16'hC3C3; busCeN = 1'b0; step(10);
    expect_wr(16'hC3C3, 16'h5656, 2'd2, 1'b0, "R4");
    we_pulse(16'h5656);
    step(12);

    // R6: address changes one sample before WE rises -> remembered, error
    busWeN = 1'b0; busData = 16'h6767; step(3);
    busAddr = 16'hD4D4; step(1);
    expect_wr(16'hC3C3, 16'h6767, 2'd3, 1'b1, "R6");
    busWeN = 1'b1; step(3);
    busCeN = 1'b1; step(12);

    // R1: asynchronous mode, clock and ADV ignored, bus address used
    cfgAsync = 1'b1; step(3);
    busCeN = 1'b0; busAddr = 16'hF0F0; step(3);
    clk_pulse();
    busWeN = 1'b0; busData = 16'h7878; step(3);
    busAddr = 16'hE5E5; step(1);
    expect_wr(16'hE5E5, 16'h7878, 2'd2, 1'b0, "R1");
    busWeN = 1'b1; step(2);
    clk_pulse();
    busAdvN = 1'b1; busAddr = 16'h1234; step(3);
    expect_wr(16'h1234, 16'h8989, 2'd2, 1'b0, "R1");
    we_pulse(16'h8989);
    busCeN = 1'b1; step(12);
    check("R1", violSeen == 0, "turnViol count in async", longint'(violSeen), 0);
    cfgAsync = 1'b0; step(3);

    // R8: clock rise two samples after a write violates
    busCeN = 1'b0; step(3);
    expect_wr(16'h1234, 16'h9A9A, 2'd3, 1'b0, "R5");
    busWeN = 1'b0; busData = 16'h9A9A; step(3);
    busWeN = 1'b1; step(2);
    busClk = 1'b1; step(3);
    busClk = 1'b0; step(8);
    check("R8", violSeen == 1, "turnViol after early clock", longint'(violSeen), 1);
    step(20);
    clk_pulse();
    step(4);
    check("R8", violSeen == 1, "turnViol after late clock", longint'(violSeen), 1);

    // R8: ADV rise three samples after a write violates
    expect_wr(16'h1234, 16'hABAB, 2'd3, 1'b0, "R5");
    busWeN = 1'b0; busData = 16'hABAB; step(3);
    busWeN = 1'b1; step(1);
    busAdvN = 1'b0; step(2);
    busAdvN = 1'b1; step(8);
    check("R8", violSeen == 2, "turnViol after early ADV rise", longint'(violSeen), 2);
    busCeN = 1'b1; step(10);

    check("R7", expQ.size() == 0, "missing strobes", longint'(expQ.size()), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule